// File: doc/BRIEF.md
# Interleaved Dual-Bank Video Memory Address Mapper

This block turns a burst request, given as a start byte address, a byte count and a direction, into a stream of 32-bit beats aimed at two physical 32-bit memory banks. In the logical view, consecutive 32-bit words alternate between the two banks, so one 64-bit logical word spans one word in each bank. Each beat carries the bank, the word index inside that bank, the flat physical word address and a 4-bit byte-enable mask. The mask covers partial bytes at an unaligned start and at a short end.

Before a write moves any data, the block sends one invalidate strobe for every 4 KB page that the write touches. A cache that holds data derived from video memory can use these strobes to drop stale pages. Requests that would run past the top of the 8 MB space are shortened so that they stop at the boundary. A request of zero bytes is accepted and then dropped. The data path and the memory arrays are outside the block.

Top module: `vram_bank_mapper`

## Requirements
- R1: Only address bits 22:0 are used. Two requests that differ only in bits 31:23 produce identical beats and strobes.
- R2: When start plus length exceeds 8 MB (0x800000), the effective length becomes 0x800000 minus the masked start. The final beat then covers the byte at 0x7FFFFF.
- R3: A beat at byte address p goes to bank p[2] and word index p[22:3]. The physical word address is bank * 2^20 + word index.
- R4: The beats of one request cover successive linear 32-bit words. The bank flips on every beat, and the word index increases by one after each bank-1 beat.
- R5: With a start offset o = addr[1:0] other than zero, the first beat enables byte lanes o up to min(3, o+len-1). Lane i is the byte whose address has low bits i. All later beats begin at lane 0.
- R6: Each beat enables at least one lane. A final beat with r < 4 remaining bytes enables lanes 0 to r-1 only.
- R7: A write first raises inv_valid for one cycle per page. The pages run in ascending order from start>>12 to (start+len-1)>>12, and all of them come before the first beat. A read raises no strobe.
- R8: A zero-length request is accepted, produces no beat and no strobe, and cmd_ready is high again in the next cycle.
- R9: While beat_valid is high and beat_ready is low, all beat fields hold steady. With beat_ready held high, one beat completes per cycle.
- R10: cmd_ready is high only when no request is in progress. After reset it is high, with beat_valid and inv_valid low. beat_last marks the final beat of a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Request offered |
| cmd_ready | output | 1 | Block idle, request taken on this edge |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 32 | Start byte address (bits above 22 ignored) |
| cmd_len | input | 32 | Length in bytes |
| inv_valid | output | 1 | One-cycle page invalidate strobe |
| inv_page | output | 11 | Index of the 4 KB page to invalidate |
| beat_valid | output | 1 | Beat offered |
| beat_ready | input | 1 | Beat taken on this edge |
| beat_write | output | 1 | Direction of the current request |
| beat_bank | output | 1 | Target bank |
| beat_word | output | 20 | Word index inside the bank |
| beat_phys | output | 21 | Flat physical word address |
| beat_be | output | 4 | Byte-lane enables |
| beat_last | output | 1 | Final beat of the request |

## Verification
A wrong byte pointer shows up at the first beat after the fault. It appears as a repeated or skipped physical word, a bank that does not flip, or a lane mask that is not contiguous after an unaligned start. The directed bursts compare every beat against a list the bench builds itself, so such faults are caught within one beat.

A wrong remaining count shows up at the end of the burst. The beat count or the tail mask is then wrong, or beat_last comes too early or too late. The clamp scenarios near 8 MB expose a count that was never limited.

A page counter fault shows up as a missing, duplicated or late strobe before the first write beat. Runs with backpressure show whether held beats stay unchanged.

// File: rtl/vram_map_pkg.sv
package vram_map_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_INVAL, ST_MOVE} vrm_state_e;

  // bytes moved by one beat: up to the next word boundary, capped by remaining
  function automatic logic [2:0] fn_take(input logic [1:0] off, input logic [2:0] rem_sat);
    logic [2:0] room;
    room = 3'd4 - {1'b0, off};
    return (rem_sat < room) ? rem_sat : room;
  endfunction

  // contiguous lane mask starting at lane off, take lanes wide
  function automatic logic [3:0] fn_byte_en(input logic [1:0] off, input logic [2:0] take);
    logic [3:0] m;
    for (int i = 0; i < 4; i++) begin
      m[i] = (i >= int'(off)) && (i < int'(off) + int'(take));
    end
    return m;
  endfunction

endpackage

// File: rtl/vrm_clamp.sv
module vrm_clamp #(
  parameter int ADDR_W = 23,
  parameter int IN_W   = 32,
  localparam int LEN_W = ADDR_W + 1
) (
  input  logic [ADDR_W-1:0] start,
  input  logic [IN_W-1:0]   len_in,
  output logic [LEN_W-1:0]  len_out
);
  logic [LEN_W-1:0] room;
  logic             over;

  always_comb begin
    room    = (LEN_W'(1) << ADDR_W) - {1'b0, start};
    over    = len_in > IN_W'(room);
    len_out = over ? room : len_in[LEN_W-1:0];
  end
endmodule

// File: rtl/vrm_inval.sv
module vrm_inval #(
  parameter int PAGE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PAGE_W-1:0] first_page,
  input  logic [PAGE_W-1:0] last_page,
  input  logic              step,
  output logic [PAGE_W-1:0] page,
  output logic              done
);
  logic [PAGE_W-1:0] cur_q, end_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0;
      end_q <= '0;
    end else if (load) begin
      cur_q <= first_page;
      end_q <= last_page;
    end else if (step && !done) begin
      cur_q <= cur_q + 1'b1;
    end
  end

  assign page = cur_q;
  assign done = (cur_q == end_q);

  // R7: the walk never passes the last page
  p_page_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step && done && !load |=> $stable(cur_q));
endmodule

// File: rtl/vrm_beat.sv
module vrm_beat
  import vram_map_pkg::*;
#(
  parameter int ADDR_W = 23,
  localparam int LEN_W  = ADDR_W + 1,
  localparam int WORD_W = ADDR_W - 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [LEN_W-1:0]  load_len,
  input  logic              advance,
  output logic              bank,
  output logic [WORD_W-1:0] word,
  output logic [3:0]        be,
  output logic              last
);
  logic [ADDR_W-1:0] cur_q;
  logic [LEN_W-1:0]  rem_q;
  logic [2:0]        rem_sat, take;

  always_comb begin
    rem_sat = (rem_q >= LEN_W'(4)) ? 3'd4 : rem_q[2:0];
    take    = fn_take(cur_q[1:0], rem_sat);
    be      = fn_byte_en(cur_q[1:0], take);
    last    = (rem_q == LEN_W'(take));
    bank    = cur_q[2];
    word    = cur_q[ADDR_W-1:3];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0;
      rem_q <= '0;
    end else if (load) begin
      cur_q <= load_addr;
      rem_q <= load_len;
    end else if (advance) begin
      cur_q <= cur_q + ADDR_W'(take);
      rem_q <= rem_q - LEN_W'(take);
    end
  end

  // R5: after any non-final beat the pointer sits on a word boundary
  p_aligned_after_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !last && !load |=> cur_q[1:0] == 2'b00);
  // R2: remaining count never underflows
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> rem_q >= LEN_W'(take));
endmodule

// File: rtl/vram_bank_mapper.sv
module vram_bank_mapper
  import vram_map_pkg::*;
#(
  parameter int ADDR_W     = 23,
  parameter int IN_W       = 32,
  parameter int PAGE_SHIFT = 12,
  localparam int LEN_W  = ADDR_W + 1,
  localparam int WORD_W = ADDR_W - 3,
  localparam int PHYS_W = ADDR_W - 2,
  localparam int PAGE_W = ADDR_W - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [IN_W-1:0]   cmd_addr,
  input  logic [IN_W-1:0]   cmd_len,
  output logic              inv_valid,
  output logic [PAGE_W-1:0] inv_page,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic              beat_write,
  output logic              beat_bank,
  output logic [WORD_W-1:0] beat_word,
  output logic [PHYS_W-1:0] beat_phys,
  output logic [3:0]        beat_be,
  output logic              beat_last
);
  vrm_state_e        state_q, state_d;
  logic              wr_q;
  logic [ADDR_W-1:0] start;
  logic [LEN_W-1:0]  eff_len;
  logic [ADDR_W-1:0] end_byte;
  logic              accept, empty_req, inv_done, beat_fire;
  logic              unused_bits;

  assign start       = cmd_addr[ADDR_W-1:0];
  assign end_byte    = start + eff_len[ADDR_W-1:0] - 1'b1;
  assign unused_bits = ^{cmd_addr[IN_W-1:ADDR_W], end_byte[PAGE_SHIFT-1:0]};

  vrm_clamp #(.ADDR_W(ADDR_W), .IN_W(IN_W)) u_clamp (
    .start(start), .len_in(cmd_len), .len_out(eff_len));

  assign cmd_ready  = (state_q == ST_IDLE);
  assign accept     = cmd_valid && cmd_ready;
  assign empty_req  = (eff_len == '0);
  assign inv_valid  = (state_q == ST_INVAL);
  assign beat_valid = (state_q == ST_MOVE);
  assign beat_fire  = beat_valid && beat_ready;
  assign beat_write = wr_q;

  vrm_inval #(.PAGE_W(PAGE_W)) u_inval (
    .clk(clk), .rst_n(rst_n),
    .load(accept),
    .first_page(start[ADDR_W-1:PAGE_SHIFT]),
    .last_page(end_byte[ADDR_W-1:PAGE_SHIFT]),
    .step(inv_valid),
    .page(inv_page), .done(inv_done));

  vrm_beat #(.ADDR_W(ADDR_W)) u_beat (
    .clk(clk), .rst_n(rst_n),
    .load(accept), .load_addr(start), .load_len(eff_len),
    .advance(beat_fire),
    .bank(beat_bank), .word(beat_word), .be(beat_be), .last(beat_last));

  assign beat_phys = {beat_bank, beat_word};

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept && !empty_req) state_d = cmd_write ? ST_INVAL : ST_MOVE;
      ST_INVAL: if (inv_done) state_d = ST_MOVE;
      ST_MOVE:  if (beat_fire && beat_last) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) wr_q <= cmd_write;
    end
  end

  // R7: strobes and beats never share a cycle
  p_one_channel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(inv_valid && beat_valid));
  // R7: consecutive strobes name consecutive pages
  p_page_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> !inv_valid || inv_page == $past(inv_page) + 1'b1);
  // R7: only writes invalidate
  p_read_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> beat_write);
  // R9: a stalled beat holds its fields
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_phys) && $stable(beat_be)
                                  && $stable(beat_last));
  // R4: bank alternates on every completed beat
  p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && !beat_last |=> beat_valid && beat_bank != $past(beat_bank));
  // R6: every beat carries data
  p_be_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> beat_be != 4'b0000);
  // R10: idle means nothing in flight
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !beat_valid && !inv_valid);
endmodule

// File: tb/vram_bank_mapper_test.sv
module vram_bank_mapper_test;
  logic        clk = 0, rst_n = 0;
  logic        cmd_valid = 0, cmd_write = 0, beat_ready = 0;
  logic [31:0] cmd_addr = 0, cmd_len = 0;
  logic        cmd_ready, inv_valid, beat_valid, beat_write, beat_bank, beat_last;
  logic [10:0] inv_page;
  logic [19:0] beat_word;
  logic [20:0] beat_phys;
  logic [3:0]  beat_be;

  vram_bank_mapper uut (.*);

  always #4 clk = ~clk;

  int n_checks = 0, n_err = 0, cyc = 0, stall_mode = 0;
  int inv_q[$], phys_q[$], be_q[$], last_q[$], cyc_q[$];
  bit order_bad = 0, prev_stall = 0;
  logic [20:0] prev_phys; logic [3:0] prev_be; logic prev_last;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    logic r;
    r = (stall_mode == 0) ? 1'b1 : (cyc % 3 == 0);
    if (prev_stall) // R9 held beat unchanged
      chk(beat_valid && beat_phys == prev_phys && beat_be == prev_be && beat_last == prev_last,
          "R9", "held beat", {beat_phys, beat_be}, {prev_phys, prev_be});
    beat_ready = r;
    if (inv_valid) begin
      inv_q.push_back(int'(inv_page));
      if (phys_q.size() != 0) order_bad = 1;
    end
    if (beat_valid && r) begin
      phys_q.push_back(int'(beat_phys)); be_q.push_back(int'(beat_be));
      last_q.push_back(int'(beat_last)); cyc_q.push_back(cyc);
    end
    prev_stall = beat_valid && !r;
    prev_phys = beat_phys; prev_be = beat_be; prev_last = beat_last;
  end

  task automatic run_cmd(bit wr, longint addr, longint len, string req);
    longint a, clen, p, rem, lw;
    int exp_phys[$], exp_be[$], exp_inv[$], waits, off, take;
    inv_q.delete(); phys_q.delete(); be_q.delete(); last_q.delete(); cyc_q.delete();
    order_bad = 0;
    a = addr & 64'h7FFFFF;
    clen = (a + len > 64'h800000) ? 64'h800000 - a : len;
    if (wr && clen > 0)
      for (longint pg = a >> 12; pg <= (a + clen - 1) >> 12; pg++) exp_inv.push_back(int'(pg));
    p = a; rem = clen;
    while (rem > 0) begin
      off = int'(p % 4);
      take = (rem < 4 - off) ? int'(rem) : 4 - off;
      lw = p >> 2;
      exp_phys.push_back(int'(((lw & 1) << 20) | (lw >> 1)));
      exp_be.push_back(((1 << (off + take)) - 1) & ~((1 << off) - 1));
      p += take; rem -= take;
    end
    @(negedge clk);
    cmd_valid = 1; cmd_write = wr; cmd_addr = addr[31:0]; cmd_len = len[31:0];
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
    waits = 0;
    while (!cmd_ready && waits < 20000) begin @(negedge clk); waits++; end
    if (clen == 0) chk(waits == 0, req, "idle delay", waits, 0);
    chk(inv_q.size() == exp_inv.size(), req, "strobe count", inv_q.size(), exp_inv.size());
    for (int i = 0; i < exp_inv.size() && i < inv_q.size(); i++)
      chk(inv_q[i] == exp_inv[i], req, "strobe page", inv_q[i], exp_inv[i]);
    chk(!order_bad, req, "strobe after beat", order_bad, 0);
    chk(phys_q.size() == exp_phys.size(), req, "beat count", phys_q.size(), exp_phys.size());
    for (int i = 0; i < exp_phys.size() && i < phys_q.size(); i++) begin
      chk(phys_q[i] == exp_phys[i], req, "phys word", phys_q[i], exp_phys[i]);
      chk(be_q[i] == exp_be[i], req, "lanes", be_q[i], exp_be[i]);
      chk(last_q[i] == (i == exp_phys.size() - 1), req, "last flag", last_q[i],
          i == exp_phys.size() - 1);
      if (stall_mode == 0 && i > 0) // R9 one beat per cycle
        chk(cyc_q[i] == cyc_q[i-1] + 1, "R9", "beat spacing", cyc_q[i] - cyc_q[i-1], 1);
    end
  endtask

  task automatic t_reset();   // R10
    chk(cmd_ready && !beat_valid && !inv_valid, "R10", "reset state",
        {cmd_ready, beat_valid, inv_valid}, 3'b100);
  endtask
  task automatic t_aligned();  run_cmd(0, 'h100, 16, "R3 R4"); endtask
  task automatic t_unaligned(); run_cmd(1, 'hFFE, 8, "R5 R6 R7"); endtask
  task automatic t_short();    run_cmd(0, 'h101, 2, "R5 R6"); endtask
  task automatic t_alias();    run_cmd(1, 'hF0000010, 8, "R1"); endtask
  task automatic t_clamp();
    run_cmd(0, 'h7FFFFA, 100, "R2");
    run_cmd(1, 'h7FFFF0, 'h40, "R2 R7");
  endtask
  task automatic t_zero();     run_cmd(1, 'h2000, 0, "R8"); endtask
  task automatic t_stall();
    stall_mode = 1; run_cmd(0, 'h203, 40, "R9 R4"); stall_mode = 0;
  endtask
  task automatic t_pages();    run_cmd(1, 'h2F00, 'h1200, "R7 R10"); endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    t_reset();
    t_aligned();
    t_unaligned();
    t_short();
    t_alias();
    t_clamp();
    t_zero();
    t_stall();
    t_pages();
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule